// File: doc/BRIEF.md
# Reverse-Carry Address Adder

This block works out bit-reversed addresses for FFT data shuffling and twiddle-factor fetches. It holds one address pointer and, on each update strobe, replaces it with the pointer combined with an offset. The combination is an add (or subtract) whose carry (or borrow) travels from the most significant bit toward the least significant bit. The result is the same as reversing the bit order of both operands, doing an ordinary add, and reversing the sum again. The stored pointer never has to be reversed.

The arithmetic is used only when the 16-bit modifier input is all zeros. With any other modifier value an update strobe leaves the pointer alone, because the other address arithmetic lives elsewhere. For a 2^k-point transform, software loads the pointer, sets the modifier to zero and sets the offset to 2^(k-1). Repeated updates then step through the 2^k-point bit-reversed order. The offset may be any value from 0 to 32768, which covers transforms of up to 65,536 points.

Top module: `rcAddrUnit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the stored pointer `ptrOut` is 0x0000.
- R2: `revActive` is 1 exactly when `modSel` equals 0x0000. Otherwise it is 0.
- R3: With `subSel`=0, `nextPtr` equals rev(rev(`ptrOut`)+rev(`offset`)), where rev mirrors all 16 bits. The carry out of bit 0 is discarded. For example, pointer 0xFFFF with offset 0x0001 gives 0xFFFE.
- R4: With `subSel`=1, `nextPtr` equals rev(rev(`ptrOut`)-rev(`offset`)) modulo 2^16. The borrow runs from the MSB toward the LSB, and any borrow out of bit 0 is discarded.
- R5: When `updateEn`=1, `ptrLoad`=0 and `revActive`=1 at a rising clock edge, `ptrOut` takes the value `nextPtr` had before that edge.
- R6: When `modSel` is nonzero, `updateEn` has no effect and `ptrOut` keeps its value.
- R7: `ptrLoad`=1 at a clock edge loads `loadValue` into `ptrOut`. This takes priority over `updateEn`.
- R8: The pointer starts at 0 and the offset is 2^(k-1). For k=3 and k=4, successive updates produce i mirrored across its low k bits, for i = 0, 1, 2, …. The sequence returns to 0 after 2^k steps. For k=3 it is 0,4,2,6,1,5,3,7.
- R9: An offset of zero leaves `nextPtr` equal to `ptrOut` in both add and subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| modSel | input | 16 | Modifier value; zero selects reverse-carry arithmetic |
| ptrLoad | input | 1 | Load strobe for the pointer |
| loadValue | input | 16 | Value written on a load |
| offset | input | 16 | Step offset |
| subSel | input | 1 | 0 = add offset, 1 = subtract offset |
| updateEn | input | 1 | Update strobe: store the next pointer |
| ptrOut | output | 16 | Stored pointer |
| nextPtr | output | 16 | Combinational next pointer |
| revActive | output | 1 | High when reverse-carry mode is selected |

## Verification
The assertions assume that the strobes and operands are settled and known at each rising edge and that reset is held for at least one edge. The clocked checks compare the stored pointer with the previous cycle's inputs and the previous cycle's `nextPtr`. The bench drives every input on the falling edge so that these assumptions always hold. Its random vectors span the whole 16-bit range of pointer and offset, and they mix add, subtract, load, update and nonzero modifier values. Directed cases cover the wrap at bit 0, the zero offset and the 8-point and 16-point sequences.

// File: rtl/rcPkg.sv
package rcPkg;
  typedef struct packed {
    logic loadPtr;
    logic stepPtr;
  } rcStrobes_t;
endpackage

// File: rtl/rcReverseAdder.sv
module rcReverseAdder #(
  parameter int W = 16
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         subSel,
  output logic [W-1:0] sum
);
  localparam int TOP = W - 1;

  logic [W-1:0] bEff;
  logic [W:1]   carry;

  // two's-complement subtract: invert B, inject 1 at the carry entry (MSB)
  assign bEff     = subSel ? ~opB : opB;
  assign carry[W] = subSel;

  for (genvar i = TOP; i >= 0; i--) begin : g_bit
    assign sum[i] = opA[i] ^ bEff[i] ^ carry[i+1];
    if (i > 0) begin : g_carry
      assign carry[i] = (opA[i] & bEff[i]) | (carry[i+1] & (opA[i] ^ bEff[i]));
    end
  end
endmodule

// File: rtl/rcDatapath.sv
module rcDatapath
  import rcPkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  rcStrobes_t   strobes,
  input  logic [W-1:0] loadValue,
  input  logic [W-1:0] offset,
  input  logic         subSel,
  output logic [W-1:0] ptrOut,
  output logic [W-1:0] nextPtr
);
  logic [W-1:0] ptrQ;

  rcReverseAdder #(.W(W)) adder_i (
    .opA    (ptrQ),
    .opB    (offset),
    .subSel (subSel),
    .sum    (nextPtr)
  );

  always_ff @(posedge clk) begin
    if (!rstN)                ptrQ <= '0;
    else if (strobes.loadPtr) ptrQ <= loadValue;
    else if (strobes.stepPtr) ptrQ <= nextPtr;
  end

  assign ptrOut = ptrQ;
endmodule

// File: rtl/rcControl.sv
module rcControl
  import rcPkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] modSel,
  input  logic         ptrLoad,
  input  logic         updateEn,
  output rcStrobes_t   strobes,
  output logic         revActive
);
  always_comb begin
    revActive       = (modSel == '0);
    strobes.loadPtr = ptrLoad;
    strobes.stepPtr = updateEn && revActive && !ptrLoad;
  end
endmodule

// File: rtl/rcAddrUnit.sv
module rcAddrUnit
  import rcPkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] modSel,
  input  logic         ptrLoad,
  input  logic [W-1:0] loadValue,
  input  logic [W-1:0] offset,
  input  logic         subSel,
  input  logic         updateEn,
  output logic [W-1:0] ptrOut,
  output logic [W-1:0] nextPtr,
  output logic         revActive
);
  rcStrobes_t strobes;

  rcControl #(.W(W)) ctrl_i (
    .modSel    (modSel),
    .ptrLoad   (ptrLoad),
    .updateEn  (updateEn),
    .strobes   (strobes),
    .revActive (revActive)
  );

  rcDatapath #(.W(W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .loadValue (loadValue),
    .offset    (offset),
    .subSel    (subSel),
    .ptrOut    (ptrOut),
    .nextPtr   (nextPtr)
  );
endmodule

// File: rtl/rcAddrUnitChk.sv
module rcAddrUnitChk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] modSel,
  input logic         ptrLoad,
  input logic [W-1:0] loadValue,
  input logic [W-1:0] offset,
  input logic         subSel,
  input logic         updateEn,
  input logic [W-1:0] ptrOut,
  input logic [W-1:0] nextPtr,
  input logic         revActive
);
  assert_mode_decode_R2: assert property (@(posedge clk) disable iff (!rstN)
    revActive == (modSel == '0));

  assert_step_store_R5: assert property (@(posedge clk) disable iff (!rstN)
    (updateEn && !ptrLoad && modSel == '0) |=> ptrOut == $past(nextPtr));

  assert_hold_other_mode_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!ptrLoad && modSel != '0) |=> $stable(ptrOut));

  assert_load_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    ptrLoad |=> ptrOut == $past(loadValue));

  assert_zero_offset_R9: assert property (@(posedge clk) disable iff (!rstN)
    (offset == '0) |-> nextPtr == ptrOut);

  // R1: the pointer is cleared by reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> ptrOut == '0);
endmodule

bind rcAddrUnit rcAddrUnitChk #(.W(W)) chk_i (.*);

// File: tb/rcAddrUnit_tb_top.sv
module rcAddrUnit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] modSel, loadValue, offset;
  logic        ptrLoad, subSel, updateEn;
  logic [15:0] ptrOut, nextPtr;
  logic        revActive;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rcAddrUnit dut_i (
    .clk(clk), .rstN(rstN), .modSel(modSel), .ptrLoad(ptrLoad),
    .loadValue(loadValue), .offset(offset), .subSel(subSel),
    .updateEn(updateEn), .ptrOut(ptrOut), .nextPtr(nextPtr),
    .revActive(revActive)
  );

  function automatic logic [15:0] mirror16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  function automatic logic [15:0] refNext(input logic [15:0] p, input logic [15:0] o,
                                          input logic sub);
    logic [15:0] s;
    s = sub ? (mirror16(p) - mirror16(o)) : (mirror16(p) + mirror16(o));
    return mirror16(s);
  endfunction

  function automatic logic [15:0] mirrorK(input int v, input int k);
    logic [15:0] r = '0;
    for (int i = 0; i < k; i++) r[i] = v[k-1-i];
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on falling edge, return after the next falling edge
  task automatic cycle(input logic ld, input logic [15:0] lv, input logic upd,
                       input logic [15:0] md, input logic [15:0] off, input logic sb);
    ptrLoad = ld; loadValue = lv; updateEn = upd; modSel = md; offset = off; subSel = sb;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic loadPtr(input logic [15:0] v);
    cycle(1'b1, v, 1'b0, 16'h0, 16'h0, 1'b0);
  endtask

  initial begin
    logic [15:0] model;
    logic [15:0] o, p, exp;
    logic sb, ld, up;
    logic [15:0] md;
    void'($urandom(32'd20240611));
    rstN = 1'b0; ptrLoad = 1'b0; updateEn = 1'b0; modSel = 16'h0;
    loadValue = 16'h0; offset = 16'h0; subSel = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1 reset", ptrOut, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", ptrOut, 16'h0000);

    // R2 decode
    modSel = 16'h0000; #1; check("R2 zero modifier", {15'h0, revActive}, 16'h1);
    modSel = 16'h801F; #1; check("R2 nonzero modifier", {15'h0, revActive}, 16'h0);
    modSel = 16'h0001; #1; check("R2 lsb modifier", {15'h0, revActive}, 16'h0);

    // R3 wrap at bit 0
    loadPtr(16'hFFFF);
    modSel = 16'h0; offset = 16'h0001; subSel = 1'b0; #1;
    check("R3 carry out of bit 0 dropped", nextPtr, 16'hFFFE);
    // R4 borrow out of bit 0
    loadPtr(16'h0000);
    offset = 16'h0001; subSel = 1'b1; #1;
    check("R4 borrow wraps", nextPtr, refNext(16'h0, 16'h1, 1'b1));
    // R9 zero offset
    loadPtr(16'hA5C3);
    offset = 16'h0; subSel = 1'b0; #1; check("R9 zero offset add", nextPtr, 16'hA5C3);
    subSel = 1'b1; #1; check("R9 zero offset sub", nextPtr, 16'hA5C3);

    // R6 update ignored outside reverse mode
    cycle(1'b0, 16'h0, 1'b1, 16'h801F, 16'h0400, 1'b0);
    check("R6 update ignored", ptrOut, 16'hA5C3);
    // R7 load wins over update
    cycle(1'b1, 16'h1234, 1'b1, 16'h0, 16'h0400, 1'b0);
    check("R7 load priority", ptrOut, 16'h1234);

    // R8 8-point and 16-point bit-reversed walks
    for (int k = 3; k <= 4; k++) begin
      loadPtr(16'h0000);
      for (int i = 1; i <= (1 << k); i++) begin
        cycle(1'b0, 16'h0, 1'b1, 16'h0, 16'(1 << (k-1)), 1'b0);
        check($sformatf("R8 k=%0d step %0d", k, i), ptrOut, mirrorK(i % (1 << k), k));
      end
    end

    // random mix: R3 R4 R5 R6 R7
    loadPtr(16'h0);
    model = 16'h0;
    for (int n = 0; n < 600; n++) begin
      o  = 16'($urandom);
      p  = 16'($urandom);
      sb = 1'($urandom);
      ld = ($urandom % 8) == 0;
      up = 1'($urandom);
      md = (($urandom % 4) == 0) ? 16'($urandom | 1) : 16'h0;
      ptrLoad = ld; loadValue = p; updateEn = up; modSel = md; offset = o; subSel = sb;
      #1;
      exp = refNext(model, o, sb);
      check(sb ? "R4 random sub" : "R3 random add", nextPtr, exp);
      if (ld) model = p;
      else if (up && md == 16'h0) model = exp;
      @(posedge clk); @(negedge clk);
      check(ld ? "R7 random load" : (md != 0 ? "R6 random hold" : "R5 random step"),
            ptrOut, model);
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule